// File: doc/BRIEF.md
# Address-Decoded AND-OR Bus Interconnect

This block joins a single bus master to a parameterised number of peripheral slots on an on-chip bus without any tristate drivers. The master presents a valid strobe, an address, a write strobe and write data. The address, write strobe and write data are fanned out unchanged to every slot. A per-slot page comparator checks only the upper address bits, above a parameterised page-offset field. The result is one enable line per slot, and the line is raised only while the master's strobe is high.

The read return path has no select index. Each slot's read word is ANDed with that slot's enable, and the gated words are then ORed into one master read word. The decode and the return path are purely combinational, so read data follows the address in the same cycle. Three flags report the state of the enable vector: a decode miss, more than one enable active at once, and a combined flag for any valid cycle whose enable vector is not one-hot.

Page numbers come from one of two generate-selected variants. In the arithmetic variant, slot i owns page `PAGE_ORIGIN + i`. In the table variant, each slot's page is read from a packed parameter vector.

Top module: `and_or_interconnect`

## Requirements
- R1: While `bus_valid` is 1, slot i's bit in `slot_en` is 1 exactly when `bus_addr[ADDR_W-1:PAGE_BITS]` equals that slot's page number; in the arithmetic variant slot i's page is `PAGE_ORIGIN + i`.
- R2: Selection depends only on the page field: the low `PAGE_BITS` address bits never change `slot_en`, and the last offset of one page and the first offset of the next select adjacent slots.
- R3: While `bus_valid` is 0, `slot_en` is all zero, `bus_rdata` is zero and all three error flags are 0.
- R4: With exactly one enable active, `bus_rdata` equals that slot's read word; read words of unselected slots have no effect on `bus_rdata`.
- R5: `slot_addr`, `slot_we` and `slot_wdata` always equal `bus_addr`, `bus_we` and `bus_wdata`, whatever the decode result.
- R6: A valid access whose page matches no slot gives an all-zero `slot_en`, a zero `bus_rdata` and `miss_err` = 1; `miss_err` is 0 otherwise.
- R7: When two or more slots share a page and it is addressed, all of their enables are 1, `multi_err` is 1 and `bus_rdata` is the bitwise OR of their read words; `multi_err` is 0 otherwise.
- R8: `sel_bad` is 1 exactly when `bus_valid` is 1 and `slot_en` is not one-hot.
- R9: Enables, read data and flags respond to address and data changes within the same cycle, with no clock edge in between.
- R10: With `USE_TABLE` = 1, slot i's page number is `SLOT_PAGE[i*TAG_W +: TAG_W]`, where `TAG_W = ADDR_W - PAGE_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_valid | input | 1 | Master bus-cycle strobe |
| bus_addr | input | ADDR_W | Master address |
| bus_we | input | 1 | Master write strobe |
| bus_wdata | input | DATA_W | Master write data |
| bus_rdata | output | DATA_W | OR of the gated slot read words |
| slot_en | output | SLOTS | One enable per slot |
| slot_addr | output | ADDR_W | Address broadcast to all slots |
| slot_we | output | 1 | Write strobe broadcast to all slots |
| slot_wdata | output | DATA_W | Write data broadcast to all slots |
| slot_rdata | input | SLOTS*DATA_W | Slot read words; slot i at bits i*DATA_W +: DATA_W |
| miss_err | output | 1 | Valid access matched no slot |
| multi_err | output | 1 | More than one slot enabled |
| sel_bad | output | 1 | Valid cycle with a non one-hot enable vector |

## Verification
The decoder is tried with addresses at the first and last slot, at both edges of one page, just below and above the mapped range, and at the top of the address space. Together these separate a true equality compare from a range compare, and also show whether offset bits leak into the decode. Every slot drives a distinct nonzero read word. A missing AND gate or a wrong slot index therefore shows up in `bus_rdata`, and changing an unselected slot's word shows whether its gate really blocks it. A second, table-configured instance with a duplicated page and a gap covers the multi-select OR result and the table field order.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE,
        SEL_ONE,
        SEL_NONE,
        SEL_MANY
    } sel_kind_e;

    function automatic sel_kind_e classify(input logic valid, input int unsigned hits);
        if (!valid)
            return SEL_IDLE;
        else if (hits == 0)
            return SEL_NONE;
        else if (hits == 1)
            return SEL_ONE;
        else
            return SEL_MANY;
    endfunction

endpackage

// File: rtl/page_decoder.sv
module page_decoder #(
    parameter int unsigned TAG_W       = 10,
    parameter int unsigned SLOTS       = 16,
    parameter bit          USE_TABLE   = 1'b0,
    parameter int unsigned PAGE_ORIGIN = 32,
    parameter logic [SLOTS*TAG_W-1:0] SLOT_PAGE = '0
) (
    input  logic [TAG_W-1:0] page_in,
    output logic [SLOTS-1:0] hit
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (USE_TABLE) begin : g_table
            localparam logic [TAG_W-1:0] PAGE_I = SLOT_PAGE[i*TAG_W +: TAG_W];
            assign hit[i] = (page_in == PAGE_I);
        end else begin : g_arith
            localparam logic [TAG_W-1:0] PAGE_I = TAG_W'(PAGE_ORIGIN + i);
            assign hit[i] = (page_in == PAGE_I);
        end
    end

endmodule

// File: rtl/and_or_combiner.sv
module and_or_combiner #(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [SLOTS-1:0]        gate_en,
    input  logic [SLOTS*DATA_W-1:0] words,
    output logic [DATA_W-1:0]       merged
);

    logic [SLOTS:0][DATA_W-1:0] chain;

    assign chain[0] = '0;

    for (genvar i = 0; i < SLOTS; i++) begin : g_gate
        logic [DATA_W-1:0] gated;
        assign gated        = words[i*DATA_W +: DATA_W] & {DATA_W{gate_en[i]}};
        assign chain[i + 1] = chain[i] | gated;
    end

    assign merged = chain[SLOTS];

endmodule

// File: rtl/select_monitor.sv
module select_monitor #(
    parameter int unsigned SLOTS = 16
) (
    input  logic             valid,
    input  logic [SLOTS-1:0] en_vec,
    output logic             none_hit,
    output logic             many_hit,
    output logic             not_onehot
);
    import ic_pkg::*;

    int unsigned hits;
    sel_kind_e   kind;

    always_comb begin
        hits = unsigned'($countones(en_vec));
        kind = classify(valid, hits);
    end

    always_comb begin
        none_hit   = 1'b0;
        many_hit   = 1'b0;
        not_onehot = 1'b0;
        unique case (kind)
            SEL_IDLE: ;
            SEL_ONE:  ;
            SEL_NONE: begin
                none_hit   = 1'b1;
                not_onehot = 1'b1;
            end
            SEL_MANY: begin
                many_hit   = 1'b1;
                not_onehot = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/and_or_interconnect.sv
module and_or_interconnect #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 22,
    parameter int unsigned PAGE_BITS   = 12,
    parameter int unsigned SLOTS       = 16,
    parameter bit          USE_TABLE   = 1'b0,
    parameter int unsigned PAGE_ORIGIN = 32,
    parameter logic [SLOTS*(ADDR_W-PAGE_BITS)-1:0] SLOT_PAGE = '0
) (
    input  logic                    bus_valid,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [SLOTS-1:0]        slot_en,
    output logic [ADDR_W-1:0]       slot_addr,
    output logic                    slot_we,
    output logic [DATA_W-1:0]       slot_wdata,
    input  logic [SLOTS*DATA_W-1:0] slot_rdata,
    output logic                    miss_err,
    output logic                    multi_err,
    output logic                    sel_bad
);

    localparam int unsigned TAG_W = ADDR_W - PAGE_BITS;

    logic [SLOTS-1:0] page_hit;

    page_decoder #(
        .TAG_W      (TAG_W),
        .SLOTS      (SLOTS),
        .USE_TABLE  (USE_TABLE),
        .PAGE_ORIGIN(PAGE_ORIGIN),
        .SLOT_PAGE  (SLOT_PAGE)
    ) u_decode (
        .page_in(bus_addr[ADDR_W-1:PAGE_BITS]),
        .hit    (page_hit)
    );

    assign slot_en    = page_hit & {SLOTS{bus_valid}};
    assign slot_addr  = bus_addr;
    assign slot_we    = bus_we;
    assign slot_wdata = bus_wdata;

    and_or_combiner #(
        .SLOTS (SLOTS),
        .DATA_W(DATA_W)
    ) u_return (
        .gate_en(slot_en),
        .words  (slot_rdata),
        .merged (bus_rdata)
    );

    select_monitor #(
        .SLOTS(SLOTS)
    ) u_monitor (
        .valid     (bus_valid),
        .en_vec    (slot_en),
        .none_hit  (miss_err),
        .many_hit  (multi_err),
        .not_onehot(sel_bad)
    );

endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic                    bus_valid,
    input logic [SLOTS-1:0]        slot_en,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic [SLOTS*DATA_W-1:0] slot_rdata,
    input logic                    miss_err,
    input logic                    multi_err,
    input logic                    sel_bad
);

    always_comb begin
        if (!$isunknown({bus_valid, slot_en, miss_err, multi_err, sel_bad})) begin
            if (!bus_valid) begin
                assert_idle_quiet_R3: assert (slot_en == '0 && bus_rdata == '0 && !sel_bad);
            end
            if (miss_err) begin
                assert_miss_empty_R6: assert (slot_en == '0 && bus_rdata == '0);
            end
            if (multi_err) begin
                assert_multi_count_R7: assert ($countones(slot_en) >= 2);
            end
            assert_bad_flag_R8: assert (sel_bad == (bus_valid && !$onehot(slot_en)));
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_en == (SLOTS'(1) << i)) begin
                    assert_single_return_R4: assert (bus_rdata == slot_rdata[i*DATA_W +: DATA_W]);
                end
            end
        end
    end

endmodule

bind and_or_interconnect ic_checker #(
    .SLOTS (SLOTS),
    .DATA_W(DATA_W)
) u_ic_checker (
    .bus_valid (bus_valid),
    .slot_en   (slot_en),
    .bus_rdata (bus_rdata),
    .slot_rdata(slot_rdata),
    .miss_err  (miss_err),
    .multi_err (multi_err),
    .sel_bad   (sel_bad)
);

// File: tb/test_and_or_interconnect.sv
module test_and_or_interconnect;

    localparam int NS = 16;
    localparam int DW = 32;
    localparam int AW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4ns clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // default instance signals
    logic             d_valid, d_we;
    logic [AW-1:0]    d_addr, d_saddr;
    logic [DW-1:0]    d_wdata, d_rdata, d_swdata;
    logic [NS-1:0]    d_en;
    logic             d_swe, d_miss, d_multi, d_bad;
    logic [NS*DW-1:0] d_srd;

    and_or_interconnect i_and_or_interconnect (
        .bus_valid (d_valid),
        .bus_addr  (d_addr),
        .bus_we    (d_we),
        .bus_wdata (d_wdata),
        .bus_rdata (d_rdata),
        .slot_en   (d_en),
        .slot_addr (d_saddr),
        .slot_we   (d_swe),
        .slot_wdata(d_swdata),
        .slot_rdata(d_srd),
        .miss_err  (d_miss),
        .multi_err (d_multi),
        .sel_bad   (d_bad)
    );

    // table instance: 4 slots, 16-bit address, 8 offset bits, pages 02,05,05,07
    logic        t_valid, t_we;
    logic [15:0] t_addr, t_saddr, t_wdata, t_rdata, t_swdata;
    logic [3:0]  t_en;
    logic        t_swe, t_miss, t_multi, t_bad;
    logic [63:0] t_srd;

    and_or_interconnect #(
        .DATA_W   (16),
        .ADDR_W   (16),
        .PAGE_BITS(8),
        .SLOTS    (4),
        .USE_TABLE(1'b1),
        .SLOT_PAGE(32'h07_05_05_02)
    ) i_and_or_interconnect_tab (
        .bus_valid (t_valid),
        .bus_addr  (t_addr),
        .bus_we    (t_we),
        .bus_wdata (t_wdata),
        .bus_rdata (t_rdata),
        .slot_en   (t_en),
        .slot_addr (t_saddr),
        .slot_we   (t_swe),
        .slot_wdata(t_swdata),
        .slot_rdata(t_srd),
        .miss_err  (t_miss),
        .multi_err (t_multi),
        .sel_bad   (t_bad)
    );

    function automatic logic [DW-1:0] word_of(input int i);
        return 32'h5A00_003C | (DW'(i) << 16) | (DW'(i) << 8);
    endfunction

    function automatic logic [DW-1:0] expect_rd(input logic [NS-1:0] en);
        logic [DW-1:0] acc = '0;
        for (int i = 0; i < NS; i++)
            if (en[i]) acc = acc | word_of(i);
        return acc;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic          v;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [NS-1:0] en;
        logic          miss;
    } vec_t;

    // slot i owns page 0x20+i, i.e. addresses 0x20000+i*0x1000 .. +0xFFF
    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b0, 22'h020000, 32'h1111_0000, 16'h0001, 1'b0},  // R1 first slot
        '{1'b1, 1'b1, 22'h02F000, 32'h2222_0001, 16'h8000, 1'b0},  // R1 last slot
        '{1'b1, 1'b0, 22'h025ABC, 32'h3333_0002, 16'h0020, 1'b0},  // R2 mid offset
        '{1'b1, 1'b1, 22'h025FFF, 32'h4444_0003, 16'h0020, 1'b0},  // R2 top offset
        '{1'b1, 1'b0, 22'h024FFF, 32'h5555_0004, 16'h0010, 1'b0},  // R2 boundary below
        '{1'b1, 1'b1, 22'h030000, 32'h6666_0005, 16'h0000, 1'b1},  // R6 just above
        '{1'b1, 1'b0, 22'h01FFFF, 32'h7777_0006, 16'h0000, 1'b1},  // R6 just below
        '{1'b0, 1'b1, 22'h023000, 32'h8888_0007, 16'h0000, 1'b0},  // R3 idle
        '{1'b1, 1'b1, 22'h02A004, 32'h9999_0008, 16'h0400, 1'b0},  // R1 write
        '{1'b1, 1'b0, 22'h3FFFFF, 32'hAAAA_0009, 16'h0000, 1'b1}   // R6 top of space
    };

    initial begin
        d_valid = 1'b0; d_we = 1'b0; d_addr = '0; d_wdata = '0;
        t_valid = 1'b0; t_we = 1'b0; t_addr = '0; t_wdata = '0;
        for (int i = 0; i < NS; i++) d_srd[i*DW +: DW] = word_of(i);
        t_srd = {16'h8008, 16'h4400, 16'h0220, 16'h0011};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: bus idle
        chk("R3 reset slot_en", 64'(d_en), 64'h0);
        chk("R3 reset bus_rdata", 64'(d_rdata), 64'h0);
        chk("R3 reset flags", 64'({d_miss, d_multi, d_bad}), 64'h0);
        rst = 1'b0;

        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            d_valid = VECS[k].v;  d_we = VECS[k].we;
            d_addr  = VECS[k].addr; d_wdata = VECS[k].wd;
            #2ns;  // R9: sampled with no clock edge since the drive
            chk("R1/R2/R3 slot_en", 64'(d_en), 64'(VECS[k].en));
            chk("R4 bus_rdata", 64'(d_rdata), 64'(expect_rd(VECS[k].en)));
            chk("R6 miss_err", 64'(d_miss), 64'(VECS[k].miss));
            chk("R7 multi_err", 64'(d_multi), 64'h0);
            chk("R8 sel_bad", 64'(d_bad), 64'(VECS[k].v && VECS[k].en == '0));
            chk("R5 slot_addr", 64'(d_saddr), 64'(VECS[k].addr));
            chk("R5 slot_we", 64'(d_swe), 64'(VECS[k].we));
            chk("R5 slot_wdata", 64'(d_swdata), 64'(VECS[k].wd));
        end

        // R4: unselected slot word changes are ignored
        @(negedge clk);
        d_valid = 1'b1; d_addr = 22'h023010;
        d_srd[7*DW +: DW] = 32'hFFFF_FFFF;
        d_srd[0 +: DW]    = 32'hFFFF_FFFF;
        #1ns;
        chk("R4 unselected ignored", 64'(d_rdata), 64'(word_of(3)));
        // R9: address moves mid-cycle, outputs follow at once
        d_addr = 22'h02E7FF;
        #1ns;
        chk("R9 same-cycle en", 64'(d_en), 64'h4000);
        chk("R9 same-cycle rdata", 64'(d_rdata), 64'(word_of(14)));
        d_srd[14*DW +: DW] = 32'h0BAD_F00D;
        #1ns;
        chk("R9 same-cycle data change", 64'(d_rdata), 64'h0BAD_F00D);

        // table variant, R10 and R7
        @(negedge clk);
        t_valid = 1'b1; t_addr = 16'h02C3; t_wdata = 16'h1234; t_we = 1'b1;
        #2ns;
        chk("R10 table slot0", 64'(t_en), 64'h1);
        chk("R10 table rdata", 64'(t_rdata), 64'h0011);
        chk("R5 table broadcast", 64'({t_saddr, t_swdata, t_swe}), 64'({16'h02C3, 16'h1234, 1'b1}));
        t_addr = 16'h07FF;
        #2ns;
        chk("R10 table slot3", 64'(t_en), 64'h8);
        chk("R10 table rdata3", 64'(t_rdata), 64'h8008);
        t_addr = 16'h0500;
        #2ns;
        chk("R7 multi enables", 64'(t_en), 64'h6);
        chk("R7 multi_err", 64'(t_multi), 64'h1);
        chk("R7 OR of words", 64'(t_rdata), 64'h4620);
        chk("R8 multi sel_bad", 64'(t_bad), 64'h1);
        chk("R6 no miss on multi", 64'(t_miss), 64'h0);
        t_addr = 16'h0300;
        #2ns;
        chk("R6 table gap miss", 64'({t_miss, t_en, t_rdata}), 64'({1'b1, 4'h0, 16'h0}));
        t_valid = 1'b0; t_addr = 16'h0500;
        #2ns;
        chk("R3 table idle", 64'({t_en, t_rdata, t_multi, t_bad}), 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule